// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block sequences the control of a datapath from a small micromemory. A microprogram counter addresses the memory. Each cycle the fetched microword is split into its fields. Its control bits are captured in an output register that drives the datapath. One datapath status input, chosen by the word's condition select code, decides which address the counter loads next.

The microword layout is chosen at elaboration by a format parameter. There are three layouts:

- **Single-target:** a condition falls through to the next sequential address.
- **Dual-target:** each word names both its taken and its not-taken successor.
- **Tagged:** a leading bit tells a plain control word apart from a conditional jump word. A jump word drives no control, so every branch costs the datapath one idle cycle.

The memory contents come from a parameter that holds one packed word per address, with address 0 in the least significant bits. The external control group carries three strobes: memory read, memory write and interrupt acknowledge.

Top module: `microseq`

## Requirements
- R1: A synchronous active-high reset sets the microPC (`upc_o`) to 0 and both control outputs to all zeros on the next rising edge.
- R2: The control outputs change only at a clock edge. After an edge they hold the internal and external control fields of the word that was addressed by the microPC before that edge.
- R3: Single-target format (FORMAT=0). Word bits, from MSB to LSB, are: internal control (ICW bits), external control (ECW bits), condition select (CSW bits), target address (AW bits). If the condition holds, the microPC loads the target. Otherwise it increments.
- R4: Dual-target format (FORMAT=1). Word bits, from MSB to LSB, are: internal control, external control, condition select, true target (AW bits), false target (AW bits). The microPC loads the true target when the condition holds and the false target otherwise.
- R5: Tagged format (FORMAT=2), tag bit (the MSB) = 0. The bits directly below the tag are internal control, then external control, and any remaining low bits are ignored. Such a word never branches: the microPC increments.
- R6: Tagged format, tag bit = 1. The bits directly below the tag are condition select, then target address. After the edge the control outputs are all zeros. The microPC loads the target if the condition holds, else it increments.
- R7: Condition select code 0 means no test. The condition is false, so the single-target and tagged formats increment and the dual-target format takes its false target.
- R8: Condition select code 1 always holds, so the branch is unconditional.
- R9: Condition select codes 2 to NCOND+1 test status bit (code − 2), sampled in the same cycle as the word is fetched.
- R10: Incrementing the microPC from the last address (2^AW − 1) wraps it to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| status_i | input | NCOND | Datapath status/condition flags |
| int_ctl_o | output | ICW | Registered internal datapath control bits |
| ext_ctl_o | output | ECW | Registered external strobes (memory read, write, interrupt ack) |
| upc_o | output | AW | Current microprogram counter |

## Verification
The bound checker covers the per-cycle rules on every edge:

- the clear after reset;
- control outputs that follow the previous fetched word;
- the increment for code 0 and the forced branch for code 1;
- idle control after a tagged jump word;
- a single-target successor that is either the increment or the target.

Some behaviour needs the bench's scenarios instead, because it depends on particular programs and status patterns. That covers:

- which status bit each code actually selects;
- the dual-target choice between its two addresses;
- the field positions within each layout;
- the wrap from the last address.

The bench runs all three formats in parallel under a pseudo-random status sequence and predicts every cycle from the layouts.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  localparam int FMT_ONE = 0;
  localparam int FMT_TWO = 1;
  localparam int FMT_MIX = 2;

  localparam int COND_NONE   = 0;
  localparam int COND_ALWAYS = 1;
  localparam int COND_BASE   = 2;

  function automatic int useq_word_w(int fmt, int icw, int ecw, int csw, int aw);
    if (fmt == FMT_TWO) return icw + ecw + csw + 2 * aw;
    if (fmt == FMT_MIX) return 1 + (((icw + ecw) > (csw + aw)) ? (icw + ecw) : (csw + aw));
    return icw + ecw + csw + aw;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 4,
  parameter int WW = 16,
  parameter logic [(2**AW)*WW-1:0] INIT = '0
) (
  input  logic [AW-1:0] addr,
  output logic [WW-1:0] word
);
  localparam int DEPTH = 2**AW;

  logic [WW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = INIT[g*WW +: WW];
  end

  assign word = mem[addr];
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import microseq_pkg::*;
#(
  parameter int FORMAT = FMT_ONE,
  parameter int ICW = 6,
  parameter int ECW = 3,
  parameter int CSW = 3,
  parameter int AW  = 4,
  parameter int WW  = 16
) (
  input  logic [WW-1:0]  word,
  output logic [ICW-1:0] int_ctl,
  output logic [ECW-1:0] ext_ctl,
  output logic [CSW-1:0] csel,
  output logic [AW-1:0]  addr_t,
  output logic [AW-1:0]  addr_f,
  output logic           is_jump
);
  if (FORMAT == FMT_MIX) begin : g_mix
    localparam int PW = WW - 1;
    logic          tag;
    logic [PW-1:0] body;
    assign tag  = word[WW-1];
    assign body = word[PW-1:0];
    always_comb begin
      if (tag) begin
        int_ctl = '0;
        ext_ctl = '0;
        csel    = body[PW-1 -: CSW];
        addr_t  = body[PW-1-CSW -: AW];
      end else begin
        int_ctl = body[PW-1 -: ICW];
        ext_ctl = body[PW-1-ICW -: ECW];
        csel    = CSW'(COND_NONE);
        addr_t  = '0;
      end
    end
    assign addr_f  = '0;
    assign is_jump = tag;
  end else if (FORMAT == FMT_TWO) begin : g_two
    assign int_ctl = word[WW-1 -: ICW];
    assign ext_ctl = word[WW-1-ICW -: ECW];
    assign csel    = word[WW-1-ICW-ECW -: CSW];
    assign addr_t  = word[2*AW-1 -: AW];
    assign addr_f  = word[AW-1:0];
    assign is_jump = 1'b0;
  end else begin : g_one
    assign int_ctl = word[WW-1 -: ICW];
    assign ext_ctl = word[WW-1-ICW -: ECW];
    assign csel    = word[WW-1-ICW-ECW -: CSW];
    assign addr_t  = word[AW-1:0];
    assign addr_f  = '0;
    assign is_jump = 1'b0;
  end
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import microseq_pkg::*;
#(
  parameter int NCOND = 4,
  parameter int CSW   = 3
) (
  input  logic [CSW-1:0]   csel,
  input  logic [NCOND-1:0] status,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    if (csel == CSW'(COND_ALWAYS)) hit = 1'b1;
    for (int i = 0; i < NCOND; i++) begin
      if (csel == CSW'(i + COND_BASE)) hit = status[i];
    end
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import microseq_pkg::*;
#(
  parameter int FORMAT = FMT_ONE,
  parameter int AW = 4
) (
  input  logic [AW-1:0] pc,
  input  logic          hit,
  input  logic [AW-1:0] addr_t,
  input  logic [AW-1:0] addr_f,
  output logic [AW-1:0] npc
);
  logic [AW-1:0] fall;

  assign fall = (FORMAT == FMT_TWO) ? addr_f : AW'(pc + 1'b1);
  assign npc  = hit ? addr_t : fall;
endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int FORMAT = FMT_ONE,
  parameter int AW     = 4,
  parameter int ICW    = 6,
  parameter int ECW    = 3,
  parameter int NCOND  = 4,
  parameter int CSW    = $clog2(NCOND + COND_BASE),
  parameter int WW     = useq_word_w(FORMAT, ICW, ECW, CSW, AW),
  parameter logic [(2**AW)*WW-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] status_i,
  output logic [ICW-1:0]   int_ctl_o,
  output logic [ECW-1:0]   ext_ctl_o,
  output logic [AW-1:0]    upc_o
);
  logic [AW-1:0]  upc_q;
  logic [ICW-1:0] int_q;
  logic [ECW-1:0] ext_q;
  logic [WW-1:0]  fetched;
  logic [ICW-1:0] dec_int;
  logic [ECW-1:0] dec_ext;
  logic [CSW-1:0] dec_csel;
  logic [AW-1:0]  dec_at;
  logic [AW-1:0]  dec_af;
  logic           dec_jump;
  logic           cond_hit;
  logic [AW-1:0]  upc_nxt;

  useq_store #(.AW(AW), .WW(WW), .INIT(INIT)) u_store (
    .addr (upc_q),
    .word (fetched)
  );

  useq_decode #(
    .FORMAT(FORMAT), .ICW(ICW), .ECW(ECW), .CSW(CSW), .AW(AW), .WW(WW)
  ) u_decode (
    .word    (fetched),
    .int_ctl (dec_int),
    .ext_ctl (dec_ext),
    .csel    (dec_csel),
    .addr_t  (dec_at),
    .addr_f  (dec_af),
    .is_jump (dec_jump)
  );

  useq_cond #(.NCOND(NCOND), .CSW(CSW)) u_cond (
    .csel   (dec_csel),
    .status (status_i),
    .hit    (cond_hit)
  );

  useq_next #(.FORMAT(FORMAT), .AW(AW)) u_next (
    .pc     (upc_q),
    .hit    (cond_hit),
    .addr_t (dec_at),
    .addr_f (dec_af),
    .npc    (upc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upc_q <= '0;
      int_q <= '0;
      ext_q <= '0;
    end else begin
      upc_q <= upc_nxt;
      int_q <= dec_int;
      ext_q <= dec_ext;
    end
  end

  assign int_ctl_o = int_q;
  assign ext_ctl_o = ext_q;
  assign upc_o     = upc_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
  import microseq_pkg::*;
#(
  parameter int FORMAT = FMT_ONE,
  parameter int AW  = 4,
  parameter int ICW = 6,
  parameter int ECW = 3,
  parameter int CSW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  upc,
  input logic [ICW-1:0] ctl_int,
  input logic [ECW-1:0] ctl_ext,
  input logic [CSW-1:0] csel,
  input logic [AW-1:0]  addr_t,
  input logic           jump,
  input logic [ICW-1:0] wint,
  input logic [ECW-1:0] wext
);
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (upc == '0 && ctl_int == '0 && ctl_ext == '0)); // R1

  AST_CTL_TRACK: assert property (@(posedge clk) disable iff (rst)
    !jump |=> (ctl_int == $past(wint) && ctl_ext == $past(wext))); // R2

  AST_ALWAYS_JUMP: assert property (@(posedge clk) disable iff (rst)
    (csel == CSW'(COND_ALWAYS)) |=> (upc == $past(addr_t))); // R8

  if (FORMAT != FMT_TWO) begin : g_step
    AST_NOTEST_STEP: assert property (@(posedge clk) disable iff (rst)
      (csel == CSW'(COND_NONE)) |=> (upc == AW'($past(upc) + 1'b1))); // R7
  end

  if (FORMAT == FMT_MIX) begin : g_mix
    AST_JUMP_NOP: assert property (@(posedge clk) disable iff (rst)
      jump |=> (ctl_int == '0 && ctl_ext == '0)); // R6
  end

  if (FORMAT == FMT_ONE) begin : g_one
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
      (csel >= CSW'(COND_BASE)) |=>
        (upc == AW'($past(upc) + 1'b1) || upc == $past(addr_t))); // R3
  end
endmodule

bind microseq useq_chk #(
  .FORMAT(FORMAT), .AW(AW), .ICW(ICW), .ECW(ECW), .CSW(CSW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .upc     (upc_q),
  .ctl_int (int_q),
  .ctl_ext (ext_q),
  .csel    (dec_csel),
  .addr_t  (dec_at),
  .jump    (dec_jump),
  .wint    (dec_int),
  .wext    (dec_ext)
);

// File: tb/tb_microseq.sv
module tb_microseq;
  localparam int AW = 4, ICW = 6, ECW = 3, NC = 4;

  function automatic logic [5:0] f_int(int i); return 6'((i * 5 + 1) % 64); endfunction
  function automatic logic [2:0] f_ext(int i); return 3'((i * 3 + 2) % 8); endfunction
  function automatic logic [2:0] f_cs(int i);  return 3'(i % 6); endfunction
  function automatic logic [3:0] f_a(int i);   return 4'((i * 7 + 3) % 16); endfunction
  function automatic logic [3:0] f_b(int i);   return 4'((i * 3 + 1) % 16); endfunction
  function automatic bit         f_tag(int i); return (i % 3) == 2; endfunction

  function automatic logic [319:0] mk(int f);
    logic [319:0] v;
    v = '0;
    for (int i = 0; i < 16; i++) begin
      if (f == 0)      v[i*16 +: 16] = {f_int(i), f_ext(i), f_cs(i), f_a(i)};
      else if (f == 1) v[i*20 +: 20] = {f_int(i), f_ext(i), f_cs(i), f_a(i), f_b(i)};
      else             v[i*10 +: 10] = f_tag(i) ? {1'b1, f_cs(i), f_a(i), 2'b00}
                                                : {1'b0, f_int(i), f_ext(i)};
    end
    return v;
  endfunction

  localparam logic [319:0] ALL0 = mk(0);
  localparam logic [319:0] ALL1 = mk(1);
  localparam logic [319:0] ALL2 = mk(2);
  localparam logic [255:0] INIT0 = ALL0[255:0];
  localparam logic [319:0] INIT1 = ALL1;
  localparam logic [159:0] INIT2 = ALL2[159:0];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] st = '0;
  always #2 clk = ~clk;

  logic [5:0] o_int [3];
  logic [2:0] o_ext [3];
  logic [3:0] o_pc  [3];

  microseq #(.FORMAT(0), .INIT(INIT0)) dut (
    .clk(clk), .rst(rst), .status_i(st),
    .int_ctl_o(o_int[0]), .ext_ctl_o(o_ext[0]), .upc_o(o_pc[0]));
  microseq #(.FORMAT(1), .INIT(INIT1)) dut_two (
    .clk(clk), .rst(rst), .status_i(st),
    .int_ctl_o(o_int[1]), .ext_ctl_o(o_ext[1]), .upc_o(o_pc[1]));
  microseq #(.FORMAT(2), .INIT(INIT2)) dut_mix (
    .clk(clk), .rst(rst), .status_i(st),
    .int_ctl_o(o_int[2]), .ext_ctl_o(o_ext[2]), .upc_o(o_pc[2]));

  int total = 0, fails = 0;
  bit done = 0;
  int mpc [3];
  int epc [3];
  logic [5:0] ei [3];
  logic [2:0] ee [3];
  string ptag [3];
  string ctag [3];
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit bcond(int cs, logic [NC-1:0] s);
    if (cs == 0) return 1'b0;
    if (cs == 1) return 1'b1;
    return s[cs-2];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic predict(int f);
    int p, cs;
    bit c;
    p  = mpc[f];
    cs = int'(f_cs(p));
    c  = bcond(cs, st);
    if (f == 2 && f_tag(p)) begin
      ei[f] = '0; ee[f] = '0; ctag[f] = "R6";
      epc[f] = c ? int'(f_a(p)) : (p + 1) % 16;
      ptag[f] = "R6";
    end else if (f == 2) begin
      ei[f] = f_int(p); ee[f] = f_ext(p); ctag[f] = "R5";
      c = 1'b0;
      epc[f] = (p + 1) % 16;
      ptag[f] = "R5";
    end else begin
      ei[f] = f_int(p); ee[f] = f_ext(p); ctag[f] = "R2";
      if (f == 0) begin
        epc[f] = c ? int'(f_a(p)) : (p + 1) % 16;
        ptag[f] = (cs == 0) ? "R7" : (cs == 1) ? "R8" : "R3";
      end else begin
        epc[f] = c ? int'(f_a(p)) : int'(f_b(p));
        ptag[f] = (cs == 1) ? "R8" : (cs > 1) ? "R9" : "R4";
      end
    end
    if (f != 1 && p == 15 && !c) ptag[f] = "R10";
  endtask

  task automatic reset_check();
    rst = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 3; f++) begin
      chk("R1", "upc", int'(o_pc[f]), 0);
      chk("R1", "int_ctl", int'(o_int[f]), 0);
      chk("R1", "ext_ctl", int'(o_ext[f]), 0);
      mpc[f] = 0;
    end
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    reset_check();
    for (int cyc = 0; cyc < 600; cyc++) begin
      if (cyc == 300) reset_check();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      st = lfsr[3:0];
      for (int f = 0; f < 3; f++) predict(f);
      @(negedge clk);
      for (int f = 0; f < 3; f++) begin
        chk(ctag[f], "int_ctl", int'(o_int[f]), int'(ei[f]));
        chk(ctag[f], "ext_ctl", int'(o_ext[f]), int'(ee[f]));
        chk(ptag[f], "upc", int'(o_pc[f]), epc[f]);
        mpc[f] = epc[f];
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog R1..: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule